// File: doc/BRIEF.md
# Programmable Sound Envelope Generator

This block produces the 4-bit envelope amplitude that a three-channel sound generator uses to shape its channel volumes over time. A free-running prescaler divides the clock by 256. A 16-bit period counter then divides it again, and the counter's period is assembled from two byte registers. Each step pulse moves a 4-bit ramp by one count. The ramp's direction, whether it repeats, whether it reverses at each end, and where it finally rests are all set by a 4-bit shape code.

Software writes bytes through a shared data bus, with one strobe per register. Writing the shape code restarts the envelope. Each channel has its own amplitude register. That register either routes the live envelope to the channel or supplies a fixed 4-bit level.

Top module: `env_amp_top`

## Requirements
- R1: During and after reset the envelope output is 15, the shape code is 0000 (Continue=0, Attack=0), both period bytes are 0, and every channel amplitude is 0 in fixed mode.
- R2: The envelope changes only on step pulses. Step pulses are spaced 256*P clock cycles apart, where P = {upper period byte, lower period byte}, and a period of 0 counts as 1.
- R3: A shape write (shape bits: bit 3 Continue, bit 2 Attack, bit 1 Alternate, bit 0 Hold) restarts the envelope. On the next cycle the output is 0 if Attack is 1 and 15 if Attack is 0, and the prescaler and period counter restart from zero.
- R4: During the first ramp the output moves by one per step, upward from 0 when Attack=1 and downward from 15 when Attack=0, so each of the 16 values lasts one step period.
- R5: With Continue=0 the output drops to 0 on the step after the first ramp and stays there. For Attack=0 this is the same as shape 1001. Bits 7 to 4 of the shape byte are ignored.
- R6: With Continue=1 and Hold=1 the output freezes after the first ramp. It freezes at the ramp's final value if Alternate=0, and at the opposite extreme if Alternate=1.
- R7: With Continue=1, Hold=0 and Alternate=0 the first ramp repeats indefinitely as a sawtooth, jumping back to its start value after its end value.
- R8: With Continue=1, Hold=0 and Alternate=1 the ramp reverses at each end. The extreme value is repeated for one step, giving a 32-step triangle.
- R9: A channel amplitude byte with bit 4 set makes that channel output the envelope in the same cycle as the envelope changes. With bit 4 clear the channel outputs bits 3 to 0. Bits 7 to 5 are ignored.
- R10: A write to one channel's amplitude register changes only that channel's output. Period-byte writes do not restart the envelope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 8 | Write data byte shared by all strobes |
| per_lo_we | input | 1 | Write strobe for the lower period byte |
| per_hi_we | input | 1 | Write strobe for the upper period byte |
| shape_we | input | 1 | Write strobe for the shape code; restarts the envelope |
| amp_we | input | 3 | Per-channel amplitude register write strobes |
| env_level | output | 4 | Current envelope value |
| chan_amp | output | 12 | Channel amplitudes, channel i in bits 4i+3 to 4i |

## Verification
Every cycle, the assertions check four things:
- the envelope holds still except on a step pulse or a restart;
- a restart loads the Attack-dependent start value;
- a frozen envelope stays frozen;
- two step pulses are never closer than the prescale ratio, and a channel register write gives its fixed level or the envelope on the next cycle.

Only the bench scenarios can show the full shape sequences: the sawtooth and triangle wrap points, the final resting levels, the period assembly from two bytes and the zero-period rule. For these, the bench compares the outputs against a step-count model on every clock.

// File: rtl/env_pkg.sv
// Shared types for the envelope generator.
// Assumes the shape code is four bits, ordered Continue, Attack, Alternate, Hold from MSB.
package env_pkg;
    typedef struct packed {
        logic cont;
        logic attack;
        logic alt;
        logic hold;
    } shape_t;

    localparam int SHAPE_W = 4;
endpackage

// File: rtl/env_step_timer.sv
// Two-stage divider that produces one-cycle step pulses for the envelope.
// Stage one divides by PRESCALE; stage two counts prescaler ticks up to the
// programmed period. A period of zero behaves as one. Assumes PRESCALE >= 2.
// A restart clears both stages so the first step comes a full interval later.
module env_step_timer #(
    parameter int PRESCALE = 256,
    parameter int PER_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam int CMP_W = PER_W + 1;

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] eff_period;
    logic             pre_tick;
    logic             per_last;

    // Decode the prescaler wrap and the end of the programmed period.
    always_comb begin
        eff_period = (period == '0) ? PER_W'(1) : period;
        pre_tick   = (pre_q == PRE_W'(PRESCALE - 1));
        per_last   = (({1'b0, per_q} + CMP_W'(1)) >= {1'b0, eff_period});
        step       = pre_tick && per_last;
    end

    // Advance the prescaler each cycle; clear it on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (pre_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Count prescaler ticks within one period; wrap when a step fires.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            per_q <= '0;
        end else if (pre_tick) begin
            per_q <= per_last ? '0 : per_q + 1'b1;
        end
    end
endmodule

// File: rtl/env_shape_seq.sv
// Envelope ramp sequencer. Holds the active shape code and a LVL_W-bit level.
// On each step pulse the level moves one count in the current direction.
// At a ramp end the shape bits choose what happens next: drop to zero and
// stop, freeze (possibly at the opposite extreme), jump back, or reverse.
// Assumes restart and step may coincide; restart wins.
module env_shape_seq
    import env_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  shape_t           shape_in,
    input  logic             step,
    output logic [LVL_W-1:0] level,
    output logic             holding
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    shape_t           shape_q;
    logic [LVL_W-1:0] level_q;
    logic             up_q;
    logic             hold_q;
    logic             at_end;

    // Detect that the ramp has reached its end in the current direction.
    always_comb begin
        at_end = up_q ? (level_q == LVL_MAX) : (level_q == '0);
    end

    // Update shape, level, direction and freeze flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_q <= '0;
            level_q <= LVL_MAX;
            up_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else if (restart) begin
            shape_q <= shape_in;
            level_q <= shape_in.attack ? '0 : LVL_MAX;
            up_q    <= shape_in.attack;
            hold_q  <= 1'b0;
        end else if (step && !hold_q) begin
            if (!at_end) begin
                level_q <= up_q ? level_q + 1'b1 : level_q - 1'b1;
            end else if (!shape_q.cont) begin
                level_q <= '0;
                hold_q  <= 1'b1;
            end else if (shape_q.hold) begin
                level_q <= shape_q.alt ? ~level_q : level_q;
                hold_q  <= 1'b1;
            end else if (shape_q.alt) begin
                up_q    <= ~up_q;
            end else begin
                level_q <= up_q ? '0 : LVL_MAX;
            end
        end
    end

    assign level   = level_q;
    assign holding = hold_q;
endmodule

// File: rtl/env_chan_mux.sv
// Per-channel amplitude registers and output selection.
// Each channel stores a mode bit (bit LVL_W of the written data) and a fixed
// level (bits LVL_W-1:0). In envelope mode the channel passes the envelope
// through combinationally; in fixed mode it drives its stored level.
module env_chan_mux #(
    parameter int NCH   = 3,
    parameter int LVL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       amp_we,
    input  logic [LVL_W:0]       amp_data,
    input  logic [LVL_W-1:0]     env_level,
    output logic [NCH*LVL_W-1:0] chan_amp
);
    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            logic             mode_q;
            logic [LVL_W-1:0] fix_q;

            // Capture this channel's mode bit and fixed level on its strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q <= 1'b0;
                    fix_q  <= '0;
                end else if (amp_we[ch]) begin
                    mode_q <= amp_data[LVL_W];
                    fix_q  <= amp_data[LVL_W-1:0];
                end
            end

            // Pick the envelope or the fixed level for this channel.
            always_comb begin
                chan_amp[ch*LVL_W +: LVL_W] = mode_q ? env_level : fix_q;
            end
        end
    endgenerate
endmodule

// File: rtl/env_amp_top.sv
// Top of the envelope generator: period byte registers, step timer, shape
// sequencer and per-channel amplitude selection. All registers share one
// write-data bus; each has its own strobe. Assumes DATA_W >= LVL_W + 1 and
// DATA_W >= SHAPE_W. Period writes take effect on the running counter
// without restarting the envelope.
module env_amp_top
    import env_pkg::*;
#(
    parameter int PRESCALE = 256,
    parameter int DATA_W   = 8,
    parameter int NCH      = 3,
    parameter int LVL_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 per_lo_we,
    input  logic                 per_hi_we,
    input  logic                 shape_we,
    input  logic [NCH-1:0]       amp_we,
    output logic [LVL_W-1:0]     env_level,
    output logic [NCH*LVL_W-1:0] chan_amp
);
    localparam int PER_W = 2 * DATA_W;

    logic [DATA_W-1:0] per_lo_q;
    logic [DATA_W-1:0] per_hi_q;
    logic              step;
    logic              seq_holding;
    shape_t            shape_in;

    // Hold the two bytes that form the envelope period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_lo_q <= '0;
            per_hi_q <= '0;
        end else begin
            if (per_lo_we) per_lo_q <= wr_data;
            if (per_hi_we) per_hi_q <= wr_data;
        end
    end

    // Extract the shape code from the low bits of the write data.
    always_comb begin
        shape_in = shape_t'(wr_data[SHAPE_W-1:0]);
    end

    env_step_timer #(
        .PRESCALE (PRESCALE),
        .PER_W    (PER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (shape_we),
        .period  ({per_hi_q, per_lo_q}),
        .step    (step)
    );

    env_shape_seq #(
        .LVL_W (LVL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (shape_we),
        .shape_in (shape_in),
        .step     (step),
        .level    (env_level),
        .holding  (seq_holding)
    );

    env_chan_mux #(
        .NCH   (NCH),
        .LVL_W (LVL_W)
    ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .amp_we    (amp_we),
        .amp_data  (wr_data[LVL_W:0]),
        .env_level (env_level),
        .chan_amp  (chan_amp)
    );
endmodule

// File: rtl/env_amp_chk.sv
// Assertion checker for env_amp_top, attached by bind below.
// Observes ports plus the internal step pulse and freeze flag.
module env_amp_chk #(
    parameter int PRESCALE = 256,
    parameter int NCH      = 3,
    parameter int LVL_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LVL_W:0]       wr_low,
    input logic                 shape_we,
    input logic [NCH-1:0]       amp_we,
    input logic [LVL_W-1:0]     env_level,
    input logic [NCH*LVL_W-1:0] chan_amp,
    input logic                 step,
    input logic                 seq_holding
);
    localparam int GAP_W = $clog2(PRESCALE) + 1;

    logic [GAP_W-1:0] gap_q;

    // Count cycles since the last step or restart, saturating at PRESCALE.
    always_ff @(posedge clk) begin
        if (!rst_n || shape_we || step) begin
            gap_q <= '0;
        end else if (gap_q != GAP_W'(PRESCALE)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: no level change without a step pulse or restart
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !shape_we) |=> $stable(env_level));

    // R2: step pulses never closer than the prescale ratio
    p_step_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !shape_we) |-> (gap_q >= GAP_W'(PRESCALE - 1)));

    // R3: restart loads the Attack-dependent start value
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shape_we |=> (env_level == ($past(wr_low[2]) ? '0 : {LVL_W{1'b1}})));

    // R6: a frozen envelope stays frozen until the next restart
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_holding && !shape_we) |=> $stable(env_level));

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
            // R9: fixed-mode write shows the written level next cycle
            p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (amp_we[ch] && !wr_low[LVL_W]) |=>
                (chan_amp[ch*LVL_W +: LVL_W] == $past(wr_low[LVL_W-1:0])));
            // R9: envelope-mode write makes the channel follow the envelope
            p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (amp_we[ch] && wr_low[LVL_W]) |=>
                (chan_amp[ch*LVL_W +: LVL_W] == env_level));
        end
    endgenerate
endmodule

bind env_amp_top env_amp_chk #(
    .PRESCALE (PRESCALE),
    .NCH      (NCH),
    .LVL_W    (LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_low      (wr_data[LVL_W:0]),
    .shape_we    (shape_we),
    .amp_we      (amp_we),
    .env_level   (env_level),
    .chan_amp    (chan_amp),
    .step        (step),
    .seq_holding (seq_holding)
);

// File: tb/tb_env_amp_top.sv
// Bench for env_amp_top: a step-count reference model compared every clock.
module tb_env_amp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        per_lo_we = 1'b0;
    logic        per_hi_we = 1'b0;
    logic        shape_we = 1'b0;
    logic [2:0]  amp_we = '0;
    logic [3:0]  env_level;
    logic [11:0] chan_amp;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit comparing = 1'b0;
    bit done = 1'b0;

    // reference model state
    int       m_cyc = 0;
    int       m_per = 1;
    logic [3:0] m_shape = 4'h0;
    logic [7:0] m_lo = '0, m_hi = '0;
    logic       m_mode [3];
    logic [3:0] m_fix  [3];

    always #4 clk = ~clk;

    env_amp_top dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .per_lo_we(per_lo_we), .per_hi_we(per_hi_we), .shape_we(shape_we),
        .amp_we(amp_we), .env_level(env_level), .chan_amp(chan_amp)
    );

    // Expected envelope after n steps of shape sh.
    function automatic int exp_env(logic [3:0] sh, int n);
        int k;
        bit up;
        if (n < 16) return sh[2] ? n : 15 - n;
        if (!sh[3]) return 0;
        if (sh[0]) return (sh[2] ^ sh[1]) ? 15 : 0;
        k = n % 16;
        if (!sh[1]) return sh[2] ? k : 15 - k;
        up = sh[2] ^ ((n / 16) % 2 == 1);
        return up ? k : 15 - k;
    endfunction

    // Model register and cycle updates.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc <= 0; m_per <= 1; m_shape <= 4'h0; m_lo <= '0; m_hi <= '0;
            for (int i = 0; i < 3; i++) begin m_mode[i] <= 1'b0; m_fix[i] <= '0; end
        end else begin
            if (per_lo_we) m_lo <= wr_data;
            if (per_hi_we) m_hi <= wr_data;
            for (int i = 0; i < 3; i++)
                if (amp_we[i]) begin m_mode[i] <= wr_data[4]; m_fix[i] <= wr_data[3:0]; end
            if (shape_we) begin
                m_cyc   <= 0;
                m_shape <= wr_data[3:0];
                m_per   <= ({m_hi, m_lo} == 16'd0) ? 1 : int'({m_hi, m_lo});
            end else begin
                m_cyc <= m_cyc + 1;
            end
        end
    end

    task automatic check(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && comparing && !done) begin
            int e;
            e = exp_env(m_shape, m_cyc / (256 * m_per));
            check(cur_req, int'(env_level), e, "env_level");
            for (int i = 0; i < 3; i++)
                check(cur_req, int'(chan_amp[i*4 +: 4]), m_mode[i] ? e : int'(m_fix[i]), "chan_amp");
        end
    end

    // sel: 0 lower period, 1 upper period, 2 shape, 3..5 channel 0..2
    task automatic wr(int sel, logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        per_lo_we = (sel == 0);
        per_hi_we = (sel == 1);
        shape_we  = (sel == 2);
        amp_we    = (sel >= 3) ? 3'(1 << (sel - 3)) : 3'b000;
        @(negedge clk);
        per_lo_we = 1'b0; per_hi_we = 1'b0; shape_we = 1'b0; amp_we = '0;
    endtask

    task automatic run_steps(int n, int per);
        repeat (n * 256 * per) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check("R1", int'(env_level), 15, "reset env_level");
        check("R1", int'(chan_amp), 0, "reset chan_amp");
        rst_n = 1'b1;
        comparing = 1'b1;
        // R1: default shape ramps down from 15 then rests at 0
        run_steps(18, 1);

        // R9 / R10: channel modes, ignored upper bits, per-channel isolation
        cur_req = "R10";
        wr(3, 8'h10);
        wr(4, 8'hE9);
        wr(5, 8'h07);
        wr(5, 8'hF3);
        check("R10", int'(chan_amp[7:4]), 9, "chan1 untouched by chan2 write");

        // R5: Continue=0, both attacks, upper shape bits set
        cur_req = "R5";
        wr(2, 8'hF4);
        check("R3", int'(env_level), 0, "restart start value attack=1");
        run_steps(20, 1);
        wr(2, 8'h30);
        run_steps(20, 1);

        // R6: hold shapes
        cur_req = "R6";
        wr(2, 8'h09); run_steps(20, 1);
        wr(2, 8'h0B); run_steps(20, 1);
        wr(2, 8'h0D); run_steps(20, 1);
        wr(2, 8'h0F); run_steps(20, 1);

        // R7: sawtooth both directions
        cur_req = "R7";
        wr(2, 8'h08); run_steps(36, 1);
        wr(2, 8'h0C); run_steps(36, 1);

        // R8: triangle both directions
        cur_req = "R8";
        wr(2, 8'h0A); run_steps(40, 1);
        wr(2, 8'h0E); run_steps(40, 1);

        // R4: mid-ramp restart and ramp steps
        cur_req = "R4";
        wr(2, 8'h0C);
        run_steps(5, 1);
        repeat (100) @(negedge clk);
        wr(2, 8'h0C);
        check("R3", int'(env_level), 0, "restart mid-ramp");
        run_steps(17, 1);

        // R2: period from both bytes and zero-as-one
        cur_req = "R2";
        wr(0, 8'h03); wr(2, 8'h08); run_steps(18, 3);
        wr(1, 8'h01); wr(0, 8'h00); wr(2, 8'h0C);
        repeat (2000) @(negedge clk);
        check("R2", int'(env_level), 0, "upper byte period no step yet");
        wr(1, 8'h00); wr(0, 8'h00); wr(2, 8'h0C); run_steps(18, 1);

        // R10: period write without restart keeps current level
        cur_req = "R10";
        wr(2, 8'h0E);
        run_steps(3, 1);
        repeat (10) @(negedge clk);
        comparing = 1'b0;
        wr(0, 8'h05);
        check("R10", int'(env_level), 3, "period write no restart");

        finish_run();
    end
endmodule